// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Port Emulator

This block models the digital side of a serial-output delta-sigma converter. A testbench or an FPGA model can use it as the device a host controller talks to. A parameterised cycle-count sequencer stands in for the analog conversion. When a conversion has run its course, the block asks for a result word on a valid/ready input and stores it. A host then reads that result over a chip-select / serial-clock / data-in / data-out port. In the same frame the host writes the settings for the next conversion.

The serial pins are sampled in the block's own clock domain. Chip select and the serial clock must each stay stable for at least two system clocks between changes. While chip select is low and no clock has arrived, the data-out pin shows the live end-of-conversion level. Each falling serial clock edge then moves one frame bit onto the pin. On the falling edge that completes a 32-bit frame, a fresh conversion starts with the settings captured in that frame.

The result input follows these back-pressure rules:
- The upstream supplier may hold `res_valid` high at any time.
- A word transfers only in a cycle where both `res_valid` and `res_ready` are high.
- `res_ready` stays high from the end of the conversion time until a word is accepted.
- A word presented while `res_ready` is low is never stored.
- If a frame completes in the same cycle as an offered word, the restart wins and the word is dropped.

Top module: `adc_serial_emu`

## Requirements
- R1: Out of reset the active settings are differential (`cfg_sgl`=0), channel pair address 0, oversampling code 3 and `cfg_twox`=0. The first conversion starts by itself with a `conv_start` pulse and lasts BASE_CYCLES*4 clocks.
- R2: A conversion lasts N = (BASE_CYCLES*(osr+1)) >> twox clocks. N is the count of clocks from the cycle in which `conv_start` is high to the first cycle in which `res_ready` is high, and `res_ready` is low while `conv_start` is high.
- R3: `res_ready` stays high until a word is accepted. A word offered while `res_ready` is low is not stored, and later reads return only the accepted word.
- R4: With `cs_n` low and no falling serial clock edge yet in the frame, `sdo` shows the end-of-conversion level. That level is 1 from the start of a conversion until its result word is accepted, and 0 afterwards.
- R5: The frame is 32 bits, sent from bit 31 to bit 0. Bit 31 is end-of-conversion, bit 30 is 0, and bits 29..0 are the accepted word: bit 29 the sign, bits 28..5 the 24-bit result MSB first, bits 4..0 the sub-LSB bits. After the k-th falling serial clock edge (k = 1..31), `sdo` carries bit 31-k.
- R6: The 32nd falling edge starts a new conversion, with a `conv_start` pulse and `res_ready` low. After that edge `sdo` reads 1, which is the next frame's end-of-conversion bit.
- R7: While `cs_n` is high, `sdo_oe` is 0 and serial clock edges are ignored. The next frame starts from bit 31.
- R8: If `cs_n` rises before the 32nd falling edge, the frame is dropped. No conversion starts, no setting changes, and the next frame starts again from bit 31 with the same data.
- R9: Data-in is sampled on the first 12 rising edges of a frame, in this order: 1, 0, enable, single-ended, address[2:0], oversampling code[3:0], twox. A valid word takes effect on the `cfg_*` ports and in the conversion length from the conversion started by that frame's 32nd falling edge.
- R10: A captured word whose first two bits are not 1 then 0, or whose enable bit is 0, leaves all settings unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial configuration data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for `sdo` (tri-state control) |
| res_valid | input | 1 | Result word offered by the supplier |
| res_ready | output | 1 | Block waits for a result word |
| res_data | input | 30 | Result word: sign, 24 result bits, 5 sub-LSB bits |
| conv_start | output | 1 | One-cycle pulse when a conversion begins |
| cfg_sgl | output | 1 | Active setting: single-ended select |
| cfg_addr | output | 3 | Active setting: channel address |
| cfg_osr | output | 4 | Active setting: oversampling code |
| cfg_twox | output | 1 | Active setting: double-speed mode |

## Verification
The bench builds the block with BASE_CYCLES=4, so the longest conversion is 64 clocks. This keeps every conversion short enough to sweep all sixteen oversampling codes against both speed settings, 32 combinations in all. Each combination also carries a different address and single-ended bit. For each combination the bench computes the expected conversion length arithmetically and reads back through a full frame the result word accepted one conversion earlier. With the small base, rejected words, aborted frames and clock activity under a high chip select can all be tested in the same short run.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;

  localparam int CFG_BITS = 12;

  typedef struct packed {
    logic       sgl;
    logic [2:0] addr;
    logic [3:0] osr;
    logic       twox;
  } conv_cfg_t;

  typedef enum logic [1:0] {
    SEQ_BOOT,
    SEQ_CONV,
    SEQ_WAIT,
    SEQ_DONE
  } seq_state_t;

  // Field layout of the captured word, first bit in the MSB position.
  function automatic conv_cfg_t unpack_cfg(input logic [CFG_BITS-1:0] w);
    conv_cfg_t c;
    c.sgl  = w[8];
    c.addr = w[7:5];
    c.osr  = w[4:1];
    c.twox = w[0];
    return c;
  endfunction

  function automatic logic cfg_word_ok(input logic [CFG_BITS-1:0] w);
    return (w[11:10] == 2'b10) && w[9];
  endfunction

endpackage

// File: rtl/adc_emu_seq.sv
module adc_emu_seq
  import adc_emu_pkg::*;
#(
  parameter int BASE_CYCLES = 64,
  parameter int RES_W       = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       osr,
  input  logic             twox,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_data,
  output logic             res_ready,
  output logic             busy,
  output logic [RES_W-1:0] res_q,
  output logic             conv_start
);
  localparam int MAX_LEN = BASE_CYCLES * 16;
  localparam int TMR_W   = $clog2(MAX_LEN + 1);

  seq_state_t       state;
  logic [TMR_W-1:0] tmr;
  logic [TMR_W-1:0] full_len;
  logic [TMR_W-1:0] conv_len;

  always_comb begin
    full_len = TMR_W'(BASE_CYCLES) * (TMR_W'(osr) + TMR_W'(1));
    conv_len = twox ? (full_len >> 1) : full_len;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= SEQ_BOOT;
      tmr        <= '0;
      res_q      <= '0;
      conv_start <= 1'b0;
    end else begin
      conv_start <= start;
      if (start) begin
        state <= SEQ_CONV;
        tmr   <= conv_len - TMR_W'(1);
      end else begin
        case (state)
          SEQ_CONV: begin
            if (tmr == '0) state <= SEQ_WAIT;
            else           tmr   <= tmr - TMR_W'(1);
          end
          SEQ_WAIT: begin
            if (res_valid) begin
              res_q <= res_data;
              state <= SEQ_DONE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign res_ready = (state == SEQ_WAIT);
  assign busy      = (state != SEQ_DONE);

  assert_ready_low_at_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !res_ready);
  assert_accept_clears_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && !start) |=> !busy);
  assert_start_sets_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !res_ready));

endmodule

// File: rtl/adc_emu_cfg.sv
module adc_emu_cfg
  import adc_emu_pkg::*;
#(
  parameter logic [3:0] DEFAULT_OSR = 4'd3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_done,
  input  logic [CFG_BITS-1:0] cfg_word,
  output conv_cfg_t           cfg_q,
  output conv_cfg_t           cfg_next
);
  localparam conv_cfg_t CFG_RESET = '{sgl: 1'b0, addr: 3'd0, osr: DEFAULT_OSR, twox: 1'b0};

  logic accept;

  assign accept   = frame_done && cfg_word_ok(cfg_word);
  assign cfg_next = accept ? unpack_cfg(cfg_word) : cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= cfg_next;
  end

  assert_bad_preamble_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && (cfg_word[11:10] != 2'b10)) |=> $stable(cfg_q));
  assert_idle_keeps_cfg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(cfg_q));

endmodule

// File: rtl/adc_emu_frame.sv
module adc_emu_frame
  import adc_emu_pkg::*;
#(
  parameter int RES_W = 30
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                sck,
  input  logic                sdi,
  input  logic                busy,
  input  logic [RES_W-1:0]    res_q,
  output logic                sdo,
  output logic                sdo_oe,
  output logic                frame_done,
  output logic [CFG_BITS-1:0] cfg_word
);
  localparam int FRAME_W = RES_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic               sck_q;
  logic [CNT_W-1:0]   bit_cnt;
  logic               sck_rise;
  logic               sck_fall;
  logic [FRAME_W-1:0] frame_w;

  assign sck_rise   = !cs_n && sck && !sck_q;
  assign sck_fall   = !cs_n && !sck && sck_q;
  assign frame_done = sck_fall && (bit_cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      bit_cnt  <= '0;
      cfg_word <= '0;
    end else begin
      sck_q <= sck;
      if (cs_n) begin
        bit_cnt  <= '0;
        cfg_word <= '0;
      end else if (frame_done) begin
        bit_cnt  <= '0;
        cfg_word <= '0;
      end else begin
        if (sck_fall) bit_cnt <= bit_cnt + CNT_W'(1);
        if (sck_rise && (bit_cnt < CNT_W'(CFG_BITS)))
          cfg_word <= {cfg_word[CFG_BITS-2:0], sdi};
      end
    end
  end

  // Bit 31 is the live end-of-conversion level.
  assign frame_w = {busy, 1'b0, res_q};
  assign sdo     = frame_w[LAST - bit_cnt];
  assign sdo_oe  = !cs_n;

  assert_idle_rewinds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (bit_cnt == '0));
  assert_done_drives_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (sdo || cs_n));

endmodule

// File: rtl/adc_serial_emu.sv
module adc_serial_emu
  import adc_emu_pkg::*;
#(
  parameter int         BASE_CYCLES = 64,
  parameter int         RES_W       = 30,
  parameter logic [3:0] DEFAULT_OSR = 4'd3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sck,
  input  logic             sdi,
  output logic             sdo,
  output logic             sdo_oe,
  input  logic             res_valid,
  output logic             res_ready,
  input  logic [RES_W-1:0] res_data,
  output logic             conv_start,
  output logic             cfg_sgl,
  output logic [2:0]       cfg_addr,
  output logic [3:0]       cfg_osr,
  output logic             cfg_twox
);
  logic                boot;
  logic                start;
  logic                frame_done;
  logic                busy;
  logic [RES_W-1:0]    res_q;
  logic [CFG_BITS-1:0] cfg_word;
  conv_cfg_t           cfg_q;
  conv_cfg_t           cfg_next;

  always_ff @(posedge clk) begin
    if (!rst_n) boot <= 1'b1;
    else        boot <= 1'b0;
  end

  assign start = boot || frame_done;

  adc_emu_frame #(.RES_W(RES_W)) frame_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .busy(busy), .res_q(res_q), .sdo(sdo), .sdo_oe(sdo_oe),
    .frame_done(frame_done), .cfg_word(cfg_word)
  );

  adc_emu_cfg #(.DEFAULT_OSR(DEFAULT_OSR)) cfg_i (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .cfg_word(cfg_word),
    .cfg_q(cfg_q), .cfg_next(cfg_next)
  );

  adc_emu_seq #(.BASE_CYCLES(BASE_CYCLES), .RES_W(RES_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .osr(cfg_next.osr), .twox(cfg_next.twox),
    .res_valid(res_valid), .res_data(res_data), .res_ready(res_ready),
    .busy(busy), .res_q(res_q), .conv_start(conv_start)
  );

  assign cfg_sgl  = cfg_q.sgl;
  assign cfg_addr = cfg_q.addr;
  assign cfg_osr  = cfg_q.osr;
  assign cfg_twox = cfg_q.twox;

  assert_idle_no_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !boot) |=> !conv_start);

endmodule

// File: tb/adc_serial_emu_tb.sv
module adc_serial_emu_tb_top;
  localparam int BASE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sck = 1'b0;
  logic        sdi = 1'b0;
  logic        sdo, sdo_oe;
  logic        res_valid = 1'b0;
  logic        res_ready;
  logic [29:0] res_data = '0;
  logic        conv_start;
  logic        cfg_sgl, cfg_twox;
  logic [2:0]  cfg_addr;
  logic [3:0]  cfg_osr;

  int checks = 0;
  int errors = 0;
  int since = 0;
  int meas_len = 0;
  int starts = 0;
  logic rdy_d = 1'b0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  adc_serial_emu #(.BASE_CYCLES(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .conv_start(conv_start), .cfg_sgl(cfg_sgl),
    .cfg_addr(cfg_addr), .cfg_osr(cfg_osr), .cfg_twox(cfg_twox)
  );

  always @(negedge clk) begin
    if (conv_start) begin
      since  <= 0;
      starts <= starts + 1;
    end else begin
      since <= since + 1;
    end
    rdy_d <= res_ready;
    if (res_ready && !rdy_d) meas_len <= since + 1;
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] mk(input logic [1:0] pre, input logic en, input logic sgl,
                                     input logic [2:0] addr, input logic [3:0] osr, input logic twox);
    return {pre, en, sgl, addr, osr, twox};
  endfunction

  function automatic int len_of(input int osr, input int twox);
    return (BASE * (osr + 1)) >> twox;
  endfunction

  task automatic run_frame(input logic [11:0] w, input int nfall,
                           output logic [31:0] rd, output logic after_bit);
    rd = '0;
    after_bit = 1'b0;
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    rd[31] = sdo;
    for (int i = 1; i <= nfall; i++) begin
      sdi = (i <= 12) ? w[12 - i] : 1'b0;
      repeat (2) @(negedge clk);
      sck = 1'b1;
      repeat (2) @(negedge clk);
      sck = 1'b0;
      repeat (2) @(negedge clk);
      if (i < 32) rd[31 - i] = sdo;
      else        after_bit = sdo;
    end
    cs_n = 1'b1;
    sdi = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic give_result(input logic [29:0] d, input int exp_len, input string req);
    while (!res_ready) @(negedge clk);
    @(negedge clk);
    chk(meas_len == exp_len, req, 32'(meas_len), 32'(exp_len));
    res_valid = 1'b1;
    res_data  = d;
    @(negedge clk);
    res_valid = 1'b0;
    res_data  = '0;
    @(negedge clk);
  endtask

  task automatic chk_cfg(input logic s, input logic [2:0] a, input logic [3:0] o, input logic t, input string req);
    chk({cfg_sgl, cfg_addr, cfg_osr, cfg_twox} == {s, a, o, t}, req,
        32'({cfg_sgl, cfg_addr, cfg_osr, cfg_twox}), 32'({s, a, o, t}));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] rd;
    logic        hi;
    logic [29:0] last_d;
    int          n0;
    int          last_len;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 / R1: reset state
    chk(sdo_oe == 1'b0, "R7 oe low while deselected", 32'(sdo_oe), 0);
    chk_cfg(1'b0, 3'd0, 4'd3, 1'b0, "R1 default settings");
    // R4: busy level shown before any clock
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(sdo_oe && sdo, "R4 eoc high while converting", 32'({sdo_oe, sdo}), 32'h3);
    cs_n = 1'b1;
    // R3: offered word while not ready must be dropped
    res_valid = 1'b1;
    res_data  = 30'h3FFF_FFFF;
    repeat (3) @(negedge clk);
    chk(res_ready == 1'b0, "R3 ready low during conversion", 32'(res_ready), 0);
    res_valid = 1'b0;
    last_d = 30'h1234_5678;
    give_result(last_d, BASE * 4, "R1 first conversion length");
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(sdo == 1'b0, "R4 eoc low after result", 32'(sdo), 0);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7: clock edges with chip select high are ignored
    for (int i = 0; i < 5; i++) begin
      sdi = 1'b1;
      sck = 1'b1; repeat (2) @(negedge clk);
      sck = 1'b0; repeat (2) @(negedge clk);
    end
    sdi = 1'b0;
    n0 = starts;

    // R2 / R5 / R6 / R9 sweep over every oversampling code and speed
    for (int k = 0; k < 32; k++) begin
      logic [3:0]  o;
      logic        t;
      logic        s;
      logic [2:0]  a;
      logic [29:0] d;
      o = 4'(k % 16);
      t = (k >= 16);
      s = k[0];
      a = 3'((k * 3) % 8);
      n0 = starts;
      run_frame(mk(2'b10, 1'b1, s, a, o, t), 32, rd, hi);
      chk(rd == {2'b00, last_d}, (k == 0) ? "R7 frame rewinds after idle clocks" : "R5 frame contents",
          rd, {2'b00, last_d});
      chk(hi == 1'b1, "R6 sdo high after 32nd edge", 32'(hi), 1);
      chk(starts == n0 + 1, "R6 one conversion started", 32'(starts), 32'(n0 + 1));
      chk_cfg(s, a, o, t, "R9 settings applied");
      cs_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(sdo == 1'b1, "R4 eoc high until result", 32'(sdo), 1);
      cs_n = 1'b1;
      d = 30'((k * 32'h0135_79BD) ^ 32'h2AC3_5E17);
      give_result(d, len_of(int'(o), int'(t)), "R2 conversion length");
      last_d = d;
    end
    last_len = len_of(15, 1);

    // R10: bad preamble, then enable clear
    run_frame(mk(2'b11, 1'b1, 1'b0, 3'd1, 4'd2, 1'b0), 32, rd, hi);
    chk_cfg(1'b1, 3'((31 * 3) % 8), 4'd15, 1'b1, "R10 bad preamble keeps settings");
    give_result(30'h0ABC_DEF0, last_len, "R10 length unchanged after bad preamble");
    last_d = 30'h0ABC_DEF0;
    run_frame(mk(2'b10, 1'b0, 1'b0, 3'd2, 4'd0, 1'b0), 32, rd, hi);
    chk_cfg(1'b1, 3'((31 * 3) % 8), 4'd15, 1'b1, "R10 enable clear keeps settings");
    chk(rd == {2'b00, last_d}, "R5 frame after rejected word", rd, {2'b00, last_d});
    give_result(30'h1555_0AAA, last_len, "R10 length unchanged after enable clear");
    last_d = 30'h1555_0AAA;

    // R8: aborted frame
    n0 = starts;
    run_frame(mk(2'b10, 1'b1, 1'b0, 3'd5, 4'd0, 1'b0), 10, rd, hi);
    repeat (4) @(negedge clk);
    chk(starts == n0, "R8 no conversion after abort", 32'(starts), 32'(n0));
    chk_cfg(1'b1, 3'((31 * 3) % 8), 4'd15, 1'b1, "R8 settings kept after abort");
    run_frame(mk(2'b00, 1'b0, 1'b0, 3'd0, 4'd0, 1'b0), 32, rd, hi);
    chk(rd == {2'b00, last_d}, "R8 rewound frame after abort", rd, {2'b00, last_d});
    give_result(30'h0000_0001, last_len, "R8 length after abort");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule